// File: doc/BRIEF.md
# Horizontal Polyphase Line Resampler

This block resamples one video line in the horizontal direction by the ratio 256/N. N is a step value set through a small register port. The input is a valid/ready stream of 16-bit packed 4:2:2 pixels. A line begins with a beat that carries the start-of-line flag. The block stores the whole line, then computes each output pixel and presents it on a valid/ready output stream. The last beat of the line carries an end-of-line flag.

An accumulator holds the source position of the current output pixel, with 8 fractional bits. Its integer part selects which stored pixels feed the filter. Its fraction selects a phase from a programmable coefficient bank. For steps up to 512 (4x enlargement down to half size) the filter has 4 taps and 8 phases. Above 512 (down to quarter size) it has 7 taps and 4 phases. Chroma goes through the same filter as luma, or, when a control bit is set, through a two-point linear blend. All settings are copied into shadow registers when a line starts, so writes made during a line apply only from the next line.

Back-pressure: the input is accepted while the block is idle or filling the line, and `in_ready` is low while results are being computed or offered. Once `out_valid` is high, `out_data` and `out_eol` stay unchanged until the cycle in which `out_ready` is high.

Top module: `rsz_hscale_top`

## Requirements
- R1: Output pixel k samples the source at position k*N/256. The position is held with 8 fractional bits, and N is valid from 64 to 1024.
- R2: For N ≤ 512 the luma value is the sum over taps t=0..3 of coef[ph*4+t] times the pixel at integer position i−1+t, where ph = fraction bits [7:5].
- R3: For N > 512 the luma value is the sum over taps t=0..6 of coef[ph*7+t] times the pixel at i−3+t, where ph = fraction bits [7:6].
- R4: Each sum has 128 added, is shifted arithmetically right by 8, and is clipped to 0..255. Coefficients are 10-bit two's complement values.
- R5: A tap position below 0 reads pixel 0. A tap position above the last pixel reads the last pixel. For chroma the same rule applies within each chroma plane.
- R6: `in_data[7:0]` is luma and `in_data[15:8]` is chroma; even pixels carry Cb and odd pixels carry Cr. Output k carries the chroma plane k&1, sampled at (k>>1)*N/256 on that plane. When the blend bit is set, chroma is (a*(256−f) + b*f + 128)>>8 of the two plane samples around the position, where f is the 8-bit fraction.
- R7: Register map. Address 0 holds the step N in bits [10:0] and the chroma blend bit in bit 16. Address 1 holds the input width in bits [15:0] and the output width in bits [31:16]. Address 2+p holds coef[2p] in bits [9:0] and coef[2p+1] in bits [25:16], for p = 0..15.
- R8: Register writes take effect only at the next accepted start-of-line beat. A line in progress uses the settings captured at its start.
- R9: Each line produces exactly the programmed output width of beats. `out_eol` is high on the last beat only.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eol` hold their values.
- R11: Beats accepted while idle without the start-of-line flag are discarded. `in_ready` is low while results are computed or offered.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | 16 | Packed pixel: chroma [15:8], luma [7:0] |
| in_sol | input | 1 | First pixel of a line |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat taken |
| out_data | output | 16 | Resampled pixel: chroma [15:8], luma [7:0] |
| out_eol | output | 1 | Last pixel of the line |

## Verification
The first result of a line becomes valid T+1 cycles after the edge that takes the last input pixel, where T is the tap count (4 or 7). Each later result is offered T+1 cycles after the previous handshake, as long as the output is not stalled. The scoreboard compares results in order at each handshake, so stalls and latency do not change the expected values. On lines where `out_ready` is held high, the monitor also counts cycles between handshakes and checks that each gap is T+1. On stalled lines it checks cycle by cycle that the offered beat stays unchanged.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int PIX_W    = 8;
  localparam int COEF_W   = 10;
  localparam int NUM_COEF = 32;
  localparam int STEP_W   = 11;
  localparam int FRAC_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int SUM_W    = 24;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_CALC, ST_SEND} rsz_state_e;

  // round to nearest, drop fraction, saturate to pixel range
  function automatic logic [PIX_W-1:0] clip_round(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] r;
    r = (s + $signed(SUM_W'(1 << (FRAC_W-1)))) >>> FRAC_W;
    if (r < 0) return '0;
    if (r > $signed(SUM_W'((1 << PIX_W) - 1))) return '1;
    return r[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/rsz_cfg_regs.sv
module rsz_cfg_regs import rsz_pkg::*; #(
  parameter int IW_W = 11,
  parameter int OW_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              load,
  output logic [STEP_W-1:0] sh_step,
  output logic              sh_blend,
  output logic [IW_W-1:0]   sh_inw,
  output logic [OW_W-1:0]   sh_outw,
  output coef_t             sh_coef [NUM_COEF]
);
  localparam int NPAIR = NUM_COEF / 2;

  logic [STEP_W-1:0] w_step;
  logic              w_blend;
  logic [IW_W-1:0]   w_inw;
  logic [OW_W-1:0]   w_outw;
  coef_t             w_coef [NUM_COEF];
  logic              unused_bits;
  assign unused_bits = ^{cfg_wdata[31:27], cfg_wdata[15:11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_step  <= STEP_W'(256);
      w_blend <= 1'b0;
      w_inw   <= IW_W'(2);
      w_outw  <= OW_W'(1);
      for (int i = 0; i < NUM_COEF; i++) w_coef[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(0)) begin
        w_step  <= cfg_wdata[STEP_W-1:0];
        w_blend <= cfg_wdata[16];
      end
      if (cfg_addr == ADDR_W'(1)) begin
        w_inw  <= cfg_wdata[IW_W-1:0];
        w_outw <= cfg_wdata[16 +: OW_W];
      end
      for (int p = 0; p < NPAIR; p++) begin
        if (cfg_addr == ADDR_W'(p + 2)) begin
          w_coef[2*p]   <= coef_t'(cfg_wdata[COEF_W-1:0]);
          w_coef[2*p+1] <= coef_t'(cfg_wdata[16 +: COEF_W]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_step  <= STEP_W'(256);
      sh_blend <= 1'b0;
      sh_inw   <= IW_W'(2);
      sh_outw  <= OW_W'(1);
      for (int i = 0; i < NUM_COEF; i++) sh_coef[i] <= '0;
    end else if (load) begin
      sh_step  <= w_step;
      sh_blend <= w_blend;
      sh_inw   <= w_inw;
      sh_outw  <= w_outw;
      for (int i = 0; i < NUM_COEF; i++) sh_coef[i] <= w_coef[i];
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sh_step) && $stable(sh_blend) && $stable(sh_inw) && $stable(sh_outw)); // R8
endmodule

// File: rtl/rsz_line_store.sv
module rsz_line_store import rsz_pkg::*; #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [2*PIX_W-1:0] wdata,
  input  logic [AW-1:0]    raddr_y,
  input  logic [AW-1:0]    raddr_c,
  output logic [PIX_W-1:0] rdata_y,
  output logic [PIX_W-1:0] rdata_c
);
  logic [PIX_W-1:0] mem_y [DEPTH];
  logic [PIX_W-1:0] mem_c [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_y[waddr] <= wdata[PIX_W-1:0];
      mem_c[waddr] <= wdata[2*PIX_W-1:PIX_W];
    end
  end

  assign rdata_y = mem_y[raddr_y];
  assign rdata_c = mem_c[raddr_c];
endmodule

// File: rtl/rsz_mac.sv
module rsz_mac import rsz_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             first,
  input  coef_t            weight,
  input  logic [PIX_W-1:0] pixel,
  output logic [PIX_W-1:0] result
);
  logic signed [SUM_W-1:0]        sum;
  logic signed [COEF_W+PIX_W:0]   prod;

  assign prod = weight * $signed({1'b0, pixel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum <= '0;
    else if (en) sum <= (first ? '0 : sum) + SUM_W'(prod);
  end

  assign result = clip_round(sum);

  // seven taps of at most 511*255 never leave this range
  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sum > -$signed(SUM_W'(1 << 21))) && (sum < $signed(SUM_W'(1 << 21)))); // R4
endmodule

// File: rtl/rsz_hscale_top.sv
module rsz_hscale_top import rsz_pkg::*; #(
  parameter int MAX_IN  = 1024,
  parameter int MAX_OUT = 1280
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_data,
  input  logic              in_sol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_data,
  output logic              out_eol
);
  localparam int AW    = $clog2(MAX_IN);
  localparam int IW_W  = AW + 1;
  localparam int OW_W  = $clog2(MAX_OUT + 1);
  localparam int ACC_W = OW_W + STEP_W;
  localparam int POS_W = ACC_W - FRAC_W + 2;
  localparam int NCH   = 2;

  rsz_state_e        state;
  logic [IW_W-1:0]   fill_cnt;
  logic [OW_W-1:0]   out_cnt;
  logic [2:0]        tap;
  logic [ACC_W-1:0]  acc_y, acc_c;

  logic [STEP_W-1:0] sh_step;
  logic              sh_blend;
  logic [IW_W-1:0]   sh_inw;
  logic [OW_W-1:0]   sh_outw;
  coef_t             sh_coef [NUM_COEF];

  logic load, wr_en, taps7, last_tap, last_out, hs_out;
  logic [AW-1:0] waddr, raddr_y, raddr_c;
  logic [PIX_W-1:0] rd_y, rd_c;
  logic [2:0] off_u, ntaps_u, ph_y, ph_c;
  logic [FRAC_W-1:0] frac_y, frac_c;
  logic [4:0] idx_y, idx_c;
  logic signed [POS_W-1:0] pos_y, pos_c, lim_y, lim_c, cl_y, cl_c, off_s, tap_s;
  coef_t wgt [NCH];
  coef_t w_blend;
  logic [PIX_W-1:0] pix [NCH];
  logic [PIX_W-1:0] res [NCH];

  assign load     = (state == ST_IDLE) && in_valid && in_sol;
  assign in_ready = (state == ST_IDLE) || ((state == ST_FILL) && (fill_cnt != sh_inw));
  assign wr_en    = in_valid && in_ready && ((state == ST_FILL) || load);
  assign waddr    = (state == ST_IDLE) ? '0 : fill_cnt[AW-1:0];

  rsz_cfg_regs #(.IW_W(IW_W), .OW_W(OW_W)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .load,
    .sh_step, .sh_blend, .sh_inw, .sh_outw, .sh_coef
  );

  rsz_line_store #(.DEPTH(MAX_IN), .AW(AW)) u_store (
    .clk, .we(wr_en), .waddr, .wdata(in_data),
    .raddr_y, .raddr_c, .rdata_y(rd_y), .rdata_c(rd_c)
  );

  // filter shape from the captured step
  assign taps7    = sh_step > STEP_W'(512);
  assign off_u    = taps7 ? 3'd3 : 3'd1;
  assign ntaps_u  = taps7 ? 3'd7 : 3'd4;
  assign last_tap = tap == (ntaps_u - 3'd1);
  assign last_out = out_cnt == (sh_outw - OW_W'(1));

  assign frac_y = acc_y[FRAC_W-1:0];
  assign frac_c = acc_c[FRAC_W-1:0];
  assign ph_y   = taps7 ? {1'b0, frac_y[7:6]} : frac_y[7:5];
  assign ph_c   = taps7 ? {1'b0, frac_c[7:6]} : frac_c[7:5];
  assign idx_y  = taps7 ? 5'(5'(ph_y) * 5'd7 + 5'(tap)) : 5'({ph_y, 2'b00} + 5'(tap));
  assign idx_c  = taps7 ? 5'(5'(ph_c) * 5'd7 + 5'(tap)) : 5'({ph_c, 2'b00} + 5'(tap));

  // tap positions with edge replication
  assign off_s = $signed({{(POS_W-3){1'b0}}, off_u});
  assign tap_s = $signed({{(POS_W-3){1'b0}}, tap});
  assign pos_y = $signed({2'b00, acc_y[ACC_W-1:FRAC_W]}) - off_s + tap_s;
  assign pos_c = $signed({2'b00, acc_c[ACC_W-1:FRAC_W]}) - off_s + tap_s;
  assign lim_y = $signed({{(POS_W-IW_W){1'b0}}, sh_inw - IW_W'(1)});
  assign lim_c = $signed({{(POS_W-IW_W+1){1'b0}}, sh_inw[IW_W-1:1] - (IW_W-1)'(1)});
  assign cl_y  = (pos_y < 0) ? '0 : (pos_y > lim_y) ? lim_y : pos_y;
  assign cl_c  = (pos_c < 0) ? '0 : (pos_c > lim_c) ? lim_c : pos_c;
  assign raddr_y = cl_y[AW-1:0];
  assign raddr_c = {cl_c[AW-2:0], out_cnt[0]};

  assign w_blend = (tap == off_u)         ? coef_t'(COEF_W'(1 << FRAC_W) - COEF_W'(frac_c)) :
                   (tap == off_u + 3'd1)  ? coef_t'(COEF_W'(frac_c)) : '0;
  assign wgt[0]  = sh_coef[idx_y];
  assign wgt[1]  = sh_blend ? w_blend : sh_coef[idx_c];
  assign pix[0]  = rd_y;
  assign pix[1]  = rd_c;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rsz_mac u_mac (
      .clk, .rst_n, .en(state == ST_CALC), .first(tap == 3'd0),
      .weight(wgt[g]), .pixel(pix[g]), .result(res[g])
    );
  end

  assign out_valid = state == ST_SEND;
  assign out_data  = {res[1], res[0]};
  assign out_eol   = out_valid && last_out;
  assign hs_out    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fill_cnt <= '0;
      out_cnt  <= '0;
      tap      <= '0;
      acc_y    <= '0;
      acc_c    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (load) begin
          fill_cnt <= IW_W'(1);
          state    <= ST_FILL;
        end
        ST_FILL: begin
          if (in_valid && in_ready) fill_cnt <= fill_cnt + IW_W'(1);
          if (fill_cnt == sh_inw) begin
            state   <= ST_CALC;
            tap     <= '0;
            acc_y   <= '0;
            acc_c   <= '0;
            out_cnt <= '0;
          end
        end
        ST_CALC: begin
          tap <= tap + 3'd1;
          if (last_tap) state <= ST_SEND;
        end
        default: if (out_ready) begin
          if (last_out) state <= ST_IDLE;
          else begin
            state   <= ST_CALC;
            tap     <= '0;
            out_cnt <= out_cnt + OW_W'(1);
            acc_y   <= acc_y + ACC_W'(sh_step);
            if (out_cnt[0]) acc_c <= acc_c + ACC_W'(sh_step);
          end
        end
      endcase
    end
  end

  // independent count of beats delivered in the current line
  logic [OW_W-1:0] chk_beats;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_beats <= '0;
    else if (load)   chk_beats <= '0;
    else if (hs_out) chk_beats <= chk_beats + OW_W'(1);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_eol)); // R10
  AST_EOL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> chk_beats == sh_outw - OW_W'(1)); // R9
  AST_RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CALC |-> ({1'b0, raddr_y} < sh_inw) && ({1'b0, raddr_c} < sh_inw)); // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FILL |-> fill_cnt <= sh_inw); // R11
endmodule

// File: tb/rsz_hscale_top_tb_top.sv
module rsz_hscale_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_sol = 1'b0, out_ready = 1'b1;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_eol;
  logic [15:0] out_data;

  always #5 clk = ~clk;

  rsz_hscale_top dut_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .in_valid, .in_ready, .in_data, .in_sol,
    .out_valid, .out_ready, .out_data, .out_eol
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit bp_mode = 1'b0;

  // reference model state
  int m_step = 256, m_blend = 0, m_inw = 2, m_outw = 1;
  int m_coef [32];
  int s_step, s_blend, s_inw, s_outw;
  int s_coef [32];
  int ly [64];
  int lc [64];

  logic [16:0] exp_q [$];
  int          gap_q [$];
  string       tag_q [$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int clamp(int v, int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int rnd_clip(int s);
    int r;
    r = (s + 128) >>> 8;
    if (r < 0) return 0;
    if (r > 255) return 255;
    return r;
  endfunction

  task automatic model_write(int a, int d);
    if (a == 0) begin m_step = d & 32'h7FF; m_blend = (d >> 16) & 1; end
    else if (a == 1) begin m_inw = d & 32'h7FF; m_outw = (d >> 16) & 32'h7FF; end
    else if (a >= 2 && a < 18) begin
      m_coef[2*(a-2)]   = int'($signed(10'(d)));
      m_coef[2*(a-2)+1] = int'($signed(10'(d >> 16)));
    end
  endtask

  task automatic cfg_write(int a, int d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'(d);
    model_write(a, d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic load_coefs();
    for (int p = 0; p < 16; p++)
      cfg_write(2 + p, {6'b0, 10'(m_coef[2*p+1]), 6'b0, 10'(m_coef[2*p])});
  endtask

  // expected beats of one line from the captured settings (R1..R6, R9)
  task automatic push_line(string tag, bit gapchk);
    int taps, off, pos, ip, fr, ph, sy, sc, a, w, m, comp;
    taps = (s_step > 512) ? 7 : 4;
    off  = (taps == 7) ? 3 : 1;
    for (int k = 0; k < s_outw; k++) begin
      pos = k * s_step; ip = pos >> 8; fr = pos & 255;
      ph = (taps == 7) ? (fr >> 6) : (fr >> 5);
      sy = 0;
      for (int t = 0; t < taps; t++) begin
        a = clamp(ip - off + t, s_inw - 1);
        sy += s_coef[ph*taps + t] * ly[a];
      end
      m = k >> 1; comp = k & 1;
      pos = m * s_step; ip = pos >> 8; fr = pos & 255;
      ph = (taps == 7) ? (fr >> 6) : (fr >> 5);
      sc = 0;
      for (int t = 0; t < taps; t++) begin
        a = clamp(ip - off + t, s_inw/2 - 1);
        if (s_blend != 0) w = (t == off) ? 256 - fr : (t == off + 1) ? fr : 0;
        else              w = s_coef[ph*taps + t];
        sc += w * lc[2*a + comp];
      end
      exp_q.push_back({(k == s_outw - 1) ? 1'b1 : 1'b0, 8'(rnd_clip(sc)), 8'(rnd_clip(sy))});
      gap_q.push_back((gapchk && k > 0) ? taps + 1 : 0);
      tag_q.push_back(tag);
    end
  endtask

  task automatic wait_accept();
    bit ok;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
  endtask

  task automatic drive_line(int n, int garbage, string tag, bit gapchk, int cfg_at, int cfg_d);
    @(posedge clk); #1;
    for (int g = 0; g < garbage; g++) begin
      in_valid = 1'b1; in_sol = 1'b0; in_data = 16'(16'hA5A5 ^ (g * 16'h1357));
      wait_accept();
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_sol = (i == 0); in_data = {8'(lc[i]), 8'(ly[i])};
      if (i == 0) begin
        s_step = m_step; s_blend = m_blend; s_inw = m_inw; s_outw = m_outw;
        for (int c = 0; c < 32; c++) s_coef[c] = m_coef[c];
        push_line(tag, gapchk);
      end
      if (i == cfg_at) begin
        cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 32'(cfg_d);
        model_write(0, cfg_d);
      end
      wait_accept();
      cfg_we = 1'b0;
    end
    in_valid = 1'b0; in_sol = 1'b0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  task automatic fill_ramp();
    for (int i = 0; i < 64; i++) begin ly[i] = (i*37 + 11) & 255; lc[i] = (i*53 + 200) & 255; end
  endtask

  task automatic fill_alt();
    for (int i = 0; i < 64; i++) begin ly[i] = (i % 2) ? 250 : 3; lc[i] = (i % 3) ? 240 : 10; end
  endtask

  // stall generator for R10
  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // scoreboard monitor
  int ncyc = 0, last_hs = 0;
  bit held = 1'b0;
  logic [16:0] held_v;
  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (held)
        check(out_valid && ({out_eol, out_data} == held_v), "R10", "stalled beat changed",
              int'({out_valid, out_eol, out_data}), int'({1'b1, held_v}));
      held = out_valid && !out_ready;
      held_v = {out_eol, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R9", "unexpected beat", int'(out_data), 0);
        else begin
          logic [16:0] e;
          int gp;
          string tg;
          e = exp_q.pop_front(); gp = gap_q.pop_front(); tg = tag_q.pop_front();
          check(out_data == e[15:0], tg, "pixel", int'(out_data), int'(e[15:0]));
          check(out_eol == e[16], "R9", "eol flag", int'(out_eol), int'(e[16]));
          check(!in_ready, "R11", "in_ready while offering", int'(in_ready), 0);
          if (gp != 0 && !bp_mode)
            check(ncyc - last_hs == gp, tg, "beat spacing", ncyc - last_hs, gp);
        end
        last_hs = ncyc;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 32; c++) m_coef[c] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R12", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R12", "in_ready after reset", int'(in_ready), 1);

    // unity step, centre-tap coefficients: output equals input (R1/R7)
    for (int p = 0; p < 8; p++) begin
      m_coef[p*4] = 0; m_coef[p*4+1] = 256; m_coef[p*4+2] = 0; m_coef[p*4+3] = 0;
    end
    load_coefs();
    cfg_write(0, 256);
    cfg_write(1, (8 << 16) | 8);
    fill_ramp();
    drive_line(8, 0, "R1/R7", 1'b1, -1, 0);

    // 2x enlargement, blend chroma, edge replication, junk before start (R5/R6/R11)
    for (int p = 0; p < 8; p++) begin
      m_coef[p*4] = -2*p; m_coef[p*4+1] = 256 - 30*p; m_coef[p*4+2] = 32*p; m_coef[p*4+3] = 0;
    end
    load_coefs();
    cfg_write(0, (1 << 16) | 128);
    cfg_write(1, (16 << 16) | 8);
    drive_line(8, 3, "R5/R6/R11", 1'b1, -1, 0);

    // 4x enlargement at the lower step limit, 4 taps (R2)
    cfg_write(0, 64);
    cfg_write(1, (16 << 16) | 4);
    drive_line(4, 0, "R2", 1'b1, -1, 0);

    // 7 taps, 4 phases, overshoot clipping, stalls (R3/R4/R10)
    for (int p = 0; p < 4; p++) begin
      m_coef[p*7]   = -20;        m_coef[p*7+1] = 30;   m_coef[p*7+2] = -100 + 10*p;
      m_coef[p*7+3] = 400 - 50*p; m_coef[p*7+4] = -100; m_coef[p*7+5] = 30 - p;
      m_coef[p*7+6] = -20 + p;
    end
    m_coef[28] = 0; m_coef[29] = 0; m_coef[30] = 0; m_coef[31] = 0;
    load_coefs();
    cfg_write(0, 768);
    cfg_write(1, (5 << 16) | 16);
    fill_alt();
    bp_mode = 1'b1;
    drive_line(16, 0, "R3/R4/R10", 1'b0, -1, 0);
    bp_mode = 1'b0;

    // step change during a line applies only to the following line (R8)
    fill_ramp();
    cfg_write(1, (4 << 16) | 16);
    drive_line(16, 0, "R8", 1'b1, 4, 1024);
    drive_line(16, 0, "R8", 1'b1, -1, 0);

    check(exp_q.size() == 0, "R9", "beats left unproduced", exp_q.size(), 0);
    finish_run();
  end
endmodule